// File: doc/BRIEF.md
# Repeated String Move Engine

The engine copies a block of elements from one place in a segmented memory space to another without help from an instruction sequencer. The caller supplies a source segment and index, a destination segment and index, a repeat count, a direction flag and an element size of byte, word or doubleword, then pulses a start strobe. The engine walks the block one element at a time. For each element it reads from the source, holds the returned data in a register, and writes that data to the destination. After each element it steps both indexes and decrements the count.

Physical addresses are real-mode style. The segment value is shifted left by four bits and the index is added to it. The sum wraps at the address width. Indexes wrap at their own width. When the count reaches zero the engine raises a one-cycle done pulse. The updated index and count values stay on the outputs, so the caller can write them back into its register file.

Top module: `strmove_engine`

## Requirements
- R1: After reset, busy, done, memRd and memWr are all 0, and srcIdx, dstIdx and count read 0.
- R2: A read address equals (srcSeg*16 + srcIdx) modulo 2^20, and a write address equals (dstSeg*16 + dstIdx) modulo 2^20, using the index values current for that element.
- R3: Each element takes three cycles. memRd is high in the first cycle. The memory returns data in the second cycle, which the engine holds. memWr is high in the third cycle and carries that held data on memWrData.
- R4: With dirFlag 0 at start, both indexes increase by the element size after each element. With dirFlag 1, both decrease by the element size. Indexes wrap modulo 2^16.
- R5: Size code 0 moves 1 byte with memByteEn 4'b0001. Size code 1 moves 2 bytes with 4'b0011. Size codes 2 and 3 move 4 bytes with 4'b1111. Data sits in the low byte lanes.
- R6: count drops by exactly 1 after each element's write. The number of writes equals the starting count, and count reads 0 once done has pulsed.
- R7: A start with countIn 0 raises done in the cycle right after start. It issues no memRd or memWr, and it leaves the indexes equal to the loaded values.
- R8: done is high for exactly one cycle, which is cycle 3*countIn+1 after the start edge. busy is high from the cycle after start through the done cycle, and low afterwards.
- R9: start, dirFlag and elemSize are sampled only at the start edge while idle. Changing any of them during a move has no effect on the addresses, data or final values.
- R10: memRd and memWr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move, sampled only when idle |
| dirFlag | input | 1 | 0 steps indexes up, 1 steps them down |
| elemSize | input | 2 | Element size code: 0 byte, 1 word, 2 or 3 doubleword |
| srcSegIn | input | 16 | Source segment value |
| srcIdxIn | input | 16 | Starting source index |
| dstSegIn | input | 16 | Destination segment value |
| dstIdxIn | input | 16 | Starting destination index |
| countIn | input | 16 | Number of elements to move |
| memRdData | input | 32 | Read data, valid the cycle after memRd |
| memAddr | output | 20 | Physical address for the current access |
| memRd | output | 1 | Read request |
| memWr | output | 1 | Write request |
| memWrData | output | 32 | Write data in the low byte lanes |
| memByteEn | output | 4 | Byte lane enables for the write |
| srcIdx | output | 16 | Current source index |
| dstIdx | output | 16 | Current destination index |
| count | output | 16 | Remaining element count |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle pulse when a move ends |

## Verification
The assertions assume a memory that always returns read data exactly one cycle after memRd, with no stall. They also assume start is only meaningful while the engine is idle. The bench memory model answers every read in the next cycle with no back-pressure. It keeps source and destination regions of each move disjoint, so the expected data can be taken from the model before the move begins. Where start, dirFlag or elemSize are changed mid-move, the change is deliberate and tests that those inputs are ignored.

// File: rtl/strmove_pkg.sv
package strmove_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_ALT4  = 2'd3
  } elemSizeT;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CAPT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } moveStateT;

  typedef struct packed {
    logic loadRegs;
    logic captureData;
    logic stepRegs;
    logic selDst;
  } ctrlStrobesT;

  function automatic int unsigned sizeBytes(elemSizeT sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_WORD: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/strmove_dpath.sv
module strmove_dpath
  import strmove_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobesT          ctl,
  input  logic                 dirFlag,
  input  logic [1:0]           elemSize,
  input  logic [SEG_W-1:0]     srcSegIn,
  input  logic [IDX_W-1:0]     srcIdxIn,
  input  logic [SEG_W-1:0]     dstSegIn,
  input  logic [IDX_W-1:0]     dstIdxIn,
  input  logic [CNT_W-1:0]     countIn,
  input  logic [DATA_W-1:0]    memRdData,
  output logic [SEG_W+3:0]     memAddr,
  output logic [DATA_W-1:0]    memWrData,
  output logic [DATA_W/8-1:0]  memByteEn,
  output logic [IDX_W-1:0]     srcIdx,
  output logic [IDX_W-1:0]     dstIdx,
  output logic [CNT_W-1:0]     count,
  output logic                 startZero,
  output logic                 lastElem
);

  localparam int ADDR_W = SEG_W + 4;
  localparam int LANES  = DATA_W / 8;

  logic [SEG_W-1:0]  srcSegQ, dstSegQ;
  logic [IDX_W-1:0]  srcIdxQ, dstIdxQ;
  logic [CNT_W-1:0]  countQ;
  logic [DATA_W-1:0] holdQ;
  logic              dirQ;
  elemSizeT          sizeQ;
  logic [IDX_W-1:0]  stepAmt;
  logic [ADDR_W-1:0] srcPhys, dstPhys;

  function automatic logic [ADDR_W-1:0] physAddr(logic [SEG_W-1:0] seg,
                                                 logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] segPart;
    logic [ADDR_W-1:0] idxPart;
    segPart = {seg, 4'b0000};
    idxPart = ADDR_W'(idx);
    return segPart + idxPart;
  endfunction

  always_comb begin
    stepAmt = IDX_W'(sizeBytes(sizeQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSegQ <= '0;
      dstSegQ <= '0;
      srcIdxQ <= '0;
      dstIdxQ <= '0;
      countQ  <= '0;
      dirQ    <= 1'b0;
      sizeQ   <= SZ_BYTE;
    end else if (ctl.loadRegs) begin
      srcSegQ <= srcSegIn;
      dstSegQ <= dstSegIn;
      srcIdxQ <= srcIdxIn;
      dstIdxQ <= dstIdxIn;
      countQ  <= countIn;
      dirQ    <= dirFlag;
      sizeQ   <= elemSizeT'(elemSize);
    end else if (ctl.stepRegs) begin
      if (dirQ) begin
        srcIdxQ <= srcIdxQ - stepAmt;
        dstIdxQ <= dstIdxQ - stepAmt;
      end else begin
        srcIdxQ <= srcIdxQ + stepAmt;
        dstIdxQ <= dstIdxQ + stepAmt;
      end
      countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (ctl.captureData) begin
      holdQ <= memRdData;
    end
  end

  assign srcPhys = physAddr(srcSegQ, srcIdxQ);
  assign dstPhys = physAddr(dstSegQ, dstIdxQ);
  assign memAddr = ctl.selDst ? dstPhys : srcPhys;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign memWrData[lane*8 +: 8] = (lane < sizeBytes(sizeQ)) ? holdQ[lane*8 +: 8] : 8'h00;
    assign memByteEn[lane]        = (lane < sizeBytes(sizeQ));
  end

  assign srcIdx    = srcIdxQ;
  assign dstIdx    = dstIdxQ;
  assign count     = countQ;
  assign startZero = (countIn == '0);
  assign lastElem  = (countQ == CNT_W'(1));

endmodule

// File: rtl/strmove_ctrl.sv
module strmove_ctrl
  import strmove_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        startZero,
  input  logic        lastElem,
  output ctrlStrobesT ctl,
  output logic        memRd,
  output logic        memWr,
  output logic        busy,
  output logic        done
);

  moveStateT stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctl.loadRegs = 1'b1;
          stateD       = startZero ? ST_FIN : ST_READ;
        end
      end
      ST_READ: stateD = ST_CAPT;
      ST_CAPT: begin
        ctl.captureData = 1'b1;
        stateD          = ST_WRITE;
      end
      ST_WRITE: begin
        ctl.selDst   = 1'b1;
        ctl.stepRegs = 1'b1;
        stateD       = lastElem ? ST_FIN : ST_READ;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memRd = (stateQ == ST_READ);
  assign memWr = (stateQ == ST_WRITE);
  assign busy  = (stateQ != ST_IDLE);
  assign done  = (stateQ == ST_FIN);

endmodule

// File: rtl/strmove_engine.sv
module strmove_engine
  import strmove_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                dirFlag,
  input  logic [1:0]          elemSize,
  input  logic [SEG_W-1:0]    srcSegIn,
  input  logic [IDX_W-1:0]    srcIdxIn,
  input  logic [SEG_W-1:0]    dstSegIn,
  input  logic [IDX_W-1:0]    dstIdxIn,
  input  logic [CNT_W-1:0]    countIn,
  input  logic [DATA_W-1:0]   memRdData,
  output logic [SEG_W+3:0]    memAddr,
  output logic                memRd,
  output logic                memWr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [IDX_W-1:0]    srcIdx,
  output logic [IDX_W-1:0]    dstIdx,
  output logic [CNT_W-1:0]    count,
  output logic                busy,
  output logic                done
);

  ctrlStrobesT ctl;
  logic        startZero;
  logic        lastElem;

  strmove_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .startZero (startZero),
    .lastElem  (lastElem),
    .ctl       (ctl),
    .memRd     (memRd),
    .memWr     (memWr),
    .busy      (busy),
    .done      (done)
  );

  strmove_dpath #(
    .SEG_W  (SEG_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dirFlag   (dirFlag),
    .elemSize  (elemSize),
    .srcSegIn  (srcSegIn),
    .srcIdxIn  (srcIdxIn),
    .dstSegIn  (dstSegIn),
    .dstIdxIn  (dstIdxIn),
    .countIn   (countIn),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memByteEn (memByteEn),
    .srcIdx    (srcIdx),
    .dstIdx    (dstIdx),
    .count     (count),
    .startZero (startZero),
    .lastElem  (lastElem)
  );

endmodule

// File: rtl/strmove_checker.sv
module strmove_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memRd,
  input logic              memWr,
  input logic [DATA_W-1:0] memRdData,
  input logic [DATA_W-1:0] memWrData,
  input logic [CNT_W-1:0]  count,
  input logic              busy,
  input logic              done
);

  p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_wr_follows_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> (!memRd && !memWr));

  p_wr_has_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd, 2));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> (count == $past(count) - 1'b1));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

bind strmove_engine strmove_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .memRd     (memRd),
  .memWr     (memWr),
  .memRdData (memRdData),
  .memWrData (memWrData),
  .count     (count),
  .busy      (busy),
  .done      (done)
);

// File: tb/strmove_engine_test.sv
module strmove_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dirFlag = 1'b0;
  logic [1:0]  elemSize = 2'd0;
  logic [15:0] srcSegIn = '0, srcIdxIn = '0, dstSegIn = '0, dstIdxIn = '0, countIn = '0;
  logic [31:0] memRdData = '0;
  logic [19:0] memAddr;
  logic        memRd, memWr;
  logic [31:0] memWrData;
  logic [3:0]  memByteEn;
  logic [15:0] srcIdx, dstIdx, count;
  logic        busy, done;

  int checks = 0;
  int failures = 0;
  int cycleNo = 0;

  typedef struct {
    logic [19:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
  } wrItemT;

  wrItemT      expWr[$];
  logic [19:0] expRd[$];
  logic [7:0]  memArr[int];

  strmove_engine uut (
    .clk(clk), .rstN(rstN), .start(start), .dirFlag(dirFlag), .elemSize(elemSize),
    .srcSegIn(srcSegIn), .srcIdxIn(srcIdxIn), .dstSegIn(dstSegIn), .dstIdxIn(dstIdxIn),
    .countIn(countIn), .memRdData(memRdData), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWrData(memWrData), .memByteEn(memByteEn), .srcIdx(srcIdx),
    .dstIdx(dstIdx), .count(count), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] getByte(logic [19:0] a);
    if (memArr.exists(int'(a))) return memArr[int'(a)];
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] phys(logic [15:0] seg, logic [15:0] idx);
    return {seg, 4'b0} + {4'b0, idx};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle read latency, byte-lane writes
  always @(posedge clk) begin
    if (memRd) begin
      for (int j = 0; j < 4; j++) memRdData[j*8 +: 8] <= getByte(memAddr + 20'(j));
    end
    if (memWr) begin
      for (int j = 0; j < 4; j++)
        if (memByteEn[j]) memArr[int'(memAddr + 20'(j))] = memWrData[j*8 +: 8];
    end
  end

  // monitor: pops expected accesses as the design issues them
  always @(negedge clk) begin
    cycleNo++;
    if (rstN) begin
      check(!(memRd && memWr), "R10 rd/wr overlap", {memRd, memWr}, 0);
      if (memRd) begin
        if (expRd.size() == 0) check(0, "R7 unexpected read", memAddr, 0);
        else begin
          logic [19:0] ea;
          ea = expRd.pop_front();
          check(memAddr == ea, "R2 read address", memAddr, ea);
        end
      end
      if (memWr) begin
        if (expWr.size() == 0) check(0, "R7 unexpected write", memAddr, 0);
        else begin
          wrItemT w;
          w = expWr.pop_front();
          check(memAddr == w.addr, "R2 write address", memAddr, w.addr);
          check(memWrData == w.data, "R3 write data", memWrData, w.data);
          check(memByteEn == w.be, "R5 byte enables", memByteEn, w.be);
        end
      end
    end
  end

  // driver: computes expected traffic and final state, runs one move
  task automatic runMove(input logic [15:0] ds, input logic [15:0] si,
                         input logic [15:0] es, input logic [15:0] di,
                         input logic [15:0] cnt, input bit dir,
                         input logic [1:0] sz, input bit disturb, input string tag);
    int n;
    logic [15:0] s, d;
    int waited;
    bit sawDone;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    s = si;
    d = di;
    for (int k = 0; k < int'(cnt); k++) begin
      wrItemT w;
      w.addr = phys(es, d);
      w.be   = (n == 1) ? 4'b0001 : (n == 2) ? 4'b0011 : 4'b1111;
      w.data = '0;
      for (int j = 0; j < n; j++) w.data[j*8 +: 8] = getByte(phys(ds, s) + 20'(j));
      expRd.push_back(phys(ds, s));
      expWr.push_back(w);
      s = dir ? s - 16'(n) : s + 16'(n);
      d = dir ? d - 16'(n) : d + 16'(n);
    end
    @(negedge clk);
    srcSegIn = ds; srcIdxIn = si; dstSegIn = es; dstIdxIn = di;
    countIn = cnt; dirFlag = dir; elemSize = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: disturb inputs while the move runs
    if (disturb) begin
      dirFlag = ~dir; elemSize = sz + 2'd1; start = 1'b1;
      srcIdxIn = si + 16'h0100; countIn = cnt + 16'd5;
    end
    waited = 1;
    sawDone = 0;
    while (waited < 400) begin
      if (waited > 1 && disturb) start = 1'b0;
      if (done) begin sawDone = 1; break; end
      check(busy, {"R8 busy during ", tag}, busy, 1);
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    check(sawDone, {"R8 done seen ", tag}, sawDone, 1);
    check(waited == 3*int'(cnt) + 1, {"R8 done cycle ", tag}, waited, 3*int'(cnt) + 1);
    @(negedge clk);
    check(!done && !busy, {"R8 done pulse ", tag}, {done, busy}, 0);
    check(srcIdx == s, {"R4 final srcIdx ", tag}, srcIdx, s);
    check(dstIdx == d, {"R4 final dstIdx ", tag}, dstIdx, d);
    check(count == 16'd0, {"R6 final count ", tag}, count, 0);
    check(expWr.size() == 0 && expRd.size() == 0, {"R6 all elements moved ", tag},
          expWr.size(), 0);
    expWr.delete();
    expRd.delete();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(0, "watchdog expired", cycleNo, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !memRd && !memWr, "R1 reset controls",
          {busy, done, memRd, memWr}, 0);
    check(srcIdx == 0 && dstIdx == 0 && count == 0, "R1 reset registers",
          {srcIdx, dstIdx, count}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R4 R5 byte forward
    runMove(16'h1000, 16'h0010, 16'h2000, 16'h0040, 16'd4, 1'b0, 2'd0, 1'b0, "byte up");
    // R4 R5 word backward
    runMove(16'h3000, 16'h0100, 16'h4000, 16'h0200, 16'd3, 1'b1, 2'd1, 1'b0, "word down");
    // R5 dword forward
    runMove(16'h5000, 16'h0000, 16'h6000, 16'h0008, 16'd2, 1'b0, 2'd2, 1'b0, "dword up");
    // R5 size code 3 behaves as 4 bytes, backward
    runMove(16'h5800, 16'h0040, 16'h6800, 16'h0080, 16'd3, 1'b1, 2'd3, 1'b0, "size3 down");
    // R7 zero count: no traffic, indexes hold loaded values
    runMove(16'h7000, 16'h1234, 16'h7100, 16'h5678, 16'd0, 1'b0, 2'd2, 1'b0, "zero count");
    check(srcIdx == 16'h1234 && dstIdx == 16'h5678, "R7 indexes unchanged",
          {srcIdx, dstIdx}, {16'h1234, 16'h5678});
    // R4 index wrap and R2 physical wrap at 2^20
    runMove(16'h0800, 16'hFFFE, 16'hFFFF, 16'h000E, 16'd3, 1'b0, 2'd0, 1'b0, "wrap");
    // R9 inputs changed during move are ignored
    runMove(16'h9000, 16'h0020, 16'hA000, 16'h0020, 16'd5, 1'b0, 2'd1, 1'b1, "disturb");
    // R6 longer run
    runMove(16'hB000, 16'h0400, 16'hC000, 16'h0800, 16'd20, 1'b1, 2'd2, 1'b0, "long");
    repeat (3) @(negedge clk);
    check(!busy && !memRd && !memWr, "R9 stays idle after move", {busy, memRd, memWr}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule